// File: doc/BRIEF.md
# CSD Shift-Add Cosine Multiplier

This block scales a signed sample by one of fourteen fixed cosine constants of the kind used in an 8-point DCT butterfly: the magnitudes cos(k·π/16)/2 for k = 1..7, each with a plus or minus sign. There is no general multiplier. Every constant is held as a 12-digit signed-digit string with digits in {−1, 0, +1}, and the product is formed from shifted copies of the sample added or subtracted. Digit groups that recur are computed once and reused after shifting. The block forms three times and five times the sample a single time, and every constant draws on those two partial sums.

The product is built over three adder levels, with a register after each level. Level one forms the shared partial sums. Level two adds two pairs of shifted operands. Level three adds the two pair sums. Samples enter and products leave on valid/ready streams. A sample transfers on a rising edge where `in_valid` and `in_ready` are both high, and a product transfers where `out_valid` and `out_ready` are both high. When the output is held back, the whole pipeline freezes and `in_ready` drops. Once a producer raises `in_valid`, it holds the sample and select steady until the transfer.

Top module: `csd_const_mult`

## Requirements
- R1: With `in_neg`=0 and `in_sel` = 1..7, the product equals the sample (two's complement, DATA_W bits) times K exactly, where K = 2008, 1892, 1702, 1448, 1137, 783, 399 for select 1 through 7. The product is DATA_W+12 bits signed and represents the sample times K/4096.
- R2: Each K lies within one unit of 4096·cos(sel·π/16)/2.
- R3: With `in_neg`=1 the product is exactly −(sample × K) for the same select.
- R4: Select code 0 yields a product of zero for any sample and either sign.
- R5: With `out_ready` held high and the pipeline empty, a sample accepted on one rising edge shows `out_valid` high after the third rising edge, counting the accepting edge. `out_valid` falls after the next edge if nothing follows.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` does not change.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Products leave in the order the samples were accepted, each exactly once.
- R8: While reset is asserted, `out_valid` is low and `in_ready` is high.
- R9: Full-scale samples −2^(DATA_W−1) and 2^(DATA_W−1)−1 give exact results for every constant and sign, without overflow.
- R10: Three times and five times the sample are formed once per accepted sample and shared by all operand slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | DATA_W | Signed input sample |
| in_sel | input | 3 | Constant magnitude select: 1..7 picks cos(k·π/16)/2, 0 gives zero |
| in_neg | input | 1 | 1 selects the negated constant |
| out_valid | output | 1 | Product stream valid |
| out_ready | input | 1 | Consumer accepts the product |
| out_product | output | DATA_W+12 | Signed product, 12 fractional bits |

## Verification
The bench feeds every sample value under every select and sign, with random gaps on the input and random back-pressure on the output. Each product is compared with a queue of products computed arithmetically. A wrong shift or sign in one operand slot breaks every product for that constant. A sign flag applied to only some slots gives a wrong magnitude for negative constants, and one applied twice gives the wrong sign. Too narrow an internal width wraps the full-scale samples. Directed sequences then target the exact latency and a stall that lasts several cycles. A stage that kept moving during the stall would overwrite the held product or drop or duplicate results, and a miscounted register would show `out_valid` one edge early or late.

// File: rtl/csd_mult_pkg.sv
package csd_mult_pkg;

  localparam int FRAC_BITS = 12;
  localparam int SEL_W     = 3;
  localparam int TERMS     = 4;
  localparam int PAIRS     = TERMS / 2;
  localparam int SH_W      = 4;

  // Source of one shifted operand: zero, x, 3x (digit group +1,0,-1) or 5x (+1,0,+1)
  typedef enum logic [1:0] {SRC_ZERO, SRC_X, SRC_X3, SRC_X5} src_e;

  typedef struct packed {
    src_e            src;
    logic            sub;
    logic [SH_W-1:0] sh;
  } term_t;

  function automatic term_t mk(input src_e s, input logic sub, input logic [SH_W-1:0] sh);
    term_t t;
    t.src = s;
    t.sub = sub;
    t.sh  = sh;
    return t;
  endfunction

  // Operand plan per magnitude; digit strings are over weights 2^-1 .. 2^-12.
  function automatic term_t term_of(input logic [SEL_W-1:0] sel, input int slot);
    term_t row [TERMS];
    for (int i = 0; i < TERMS; i++) row[i] = mk(SRC_ZERO, 1'b0, '0);
    case (sel)
      // 1 0 0 0 0 0 -1 0 -1 0 0 0 : 2048x - 8*(5x) = 2008x
      3'd1: begin
        row[0] = mk(SRC_X,  1'b0, 4'd11);
        row[1] = mk(SRC_X5, 1'b1, 4'd3);
      end
      // 1 0 0 0 -1 0 -1 0 0 1 0 0 : 2048x - 32*(5x) + 4x = 1892x
      3'd2: begin
        row[0] = mk(SRC_X,  1'b0, 4'd11);
        row[1] = mk(SRC_X5, 1'b1, 4'd5);
        row[2] = mk(SRC_X,  1'b0, 4'd2);
      end
      // 1 0 -1 0 1 0 1 0 1 0 -1 0 : 512*(3x) + 32*(5x) + 2*(3x) = 1702x
      3'd3: begin
        row[0] = mk(SRC_X3, 1'b0, 4'd9);
        row[1] = mk(SRC_X5, 1'b0, 4'd5);
        row[2] = mk(SRC_X3, 1'b0, 4'd1);
      end
      // 1 0 -1 0 -1 0 1 0 1 0 0 0 : 512*(3x) - 128x + 8*(5x) = 1448x
      3'd4: begin
        row[0] = mk(SRC_X3, 1'b0, 4'd9);
        row[1] = mk(SRC_X,  1'b1, 4'd7);
        row[2] = mk(SRC_X5, 1'b0, 4'd3);
      end
      // 0 1 0 0 1 0 0 -1 0 0 0 1 : 1024x + 128x - 16x + x = 1137x
      3'd5: begin
        row[0] = mk(SRC_X, 1'b0, 4'd10);
        row[1] = mk(SRC_X, 1'b0, 4'd7);
        row[2] = mk(SRC_X, 1'b1, 4'd4);
        row[3] = mk(SRC_X, 1'b0, 4'd0);
      end
      // 0 1 0 -1 0 0 0 1 0 0 0 -1 : 256*(3x) + 16x - x = 783x
      3'd6: begin
        row[0] = mk(SRC_X3, 1'b0, 4'd8);
        row[1] = mk(SRC_X,  1'b0, 4'd4);
        row[2] = mk(SRC_X,  1'b1, 4'd0);
      end
      // 0 0 1 0 -1 0 0 1 0 0 0 -1 : 128*(3x) + 16x - x = 399x
      3'd7: begin
        row[0] = mk(SRC_X3, 1'b0, 4'd7);
        row[1] = mk(SRC_X,  1'b0, 4'd4);
        row[2] = mk(SRC_X,  1'b1, 4'd0);
      end
      default: ;
    endcase
    return row[slot];
  endfunction

endpackage

// File: rtl/csd_base_stage.sv
module csd_base_stage
  import csd_mult_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROD_W = DATA_W + FRAC_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [SEL_W-1:0]         in_sel,
  input  logic                     in_neg,
  output logic                     va,
  output logic signed [PROD_W-1:0] xa,
  output logic signed [PROD_W-1:0] x3a,
  output logic signed [PROD_W-1:0] x5a,
  output logic [SEL_W-1:0]         sela,
  output logic                     nega
);

  localparam int EXT_W = PROD_W - DATA_W;

  logic signed [PROD_W-1:0] xe, x3, x5;

  // Level one: the two shared digit groups
  always_comb begin
    xe = {{EXT_W{in_sample[DATA_W-1]}}, in_sample};
    x3 = (xe <<< 2) - xe;
    x5 = (xe <<< 2) + xe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va   <= 1'b0;
      xa   <= '0;
      x3a  <= '0;
      x5a  <= '0;
      sela <= '0;
      nega <= 1'b0;
    end else if (adv) begin
      va <= in_valid;
      if (in_valid) begin
        xa   <= xe;
        x3a  <= x3;
        x5a  <= x5;
        sela <= in_sel;
        nega <= in_neg;
      end
    end
  end

  // R10: the shared multiples really are 3x and 5x of the held sample
  a_r10_shared_bases: assert property (@(posedge clk) disable iff (!rst_n)
    va |-> (x3a == PROD_W'(xa * 3)) && (x5a == PROD_W'(xa * 5)));

endmodule

// File: rtl/csd_pair_stage.sv
module csd_pair_stage
  import csd_mult_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROD_W = DATA_W + FRAC_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          va,
  input  logic signed [PROD_W-1:0]      xa,
  input  logic signed [PROD_W-1:0]      x3a,
  input  logic signed [PROD_W-1:0]      x5a,
  input  logic [SEL_W-1:0]              sela,
  input  logic                          nega,
  output logic                          vb,
  output logic [PAIRS-1:0][PROD_W-1:0]  psum
);

  logic signed [PROD_W-1:0] op [TERMS];

  for (genvar j = 0; j < TERMS; j++) begin : g_slot
    term_t                    t;
    logic signed [PROD_W-1:0] base;
    logic signed [PROD_W-1:0] shifted;
    always_comb begin
      t = term_of(sela, j);
      case (t.src)
        SRC_X:   base = xa;
        SRC_X3:  base = x3a;
        SRC_X5:  base = x5a;
        default: base = '0;
      endcase
      shifted = base <<< t.sh;
      op[j]   = (t.sub ^ nega) ? -shifted : shifted;
    end
  end

  // Level two: pairwise sums, registered
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic signed [PROD_W-1:0] sum;
    assign sum = op[2*p] + op[2*p+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                psum[p] <= '0;
      else if (adv && va)        psum[p] <= sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vb <= 1'b0;
    else if (adv) vb <= va;
  end

  // R4: select code 0 leaves both pair sums at zero
  a_r4_zero_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (va && adv && sela == '0) |=> (vb && psum == '0));

endmodule

// File: rtl/csd_final_stage.sv
module csd_final_stage
  import csd_mult_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PROD_W = DATA_W + FRAC_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic                         vb,
  input  logic [PAIRS-1:0][PROD_W-1:0] psum,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [PROD_W-1:0]            out_product
);

  logic signed [PROD_W-1:0] total;

  // Level three: sum of the pair results
  always_comb begin
    total = '0;
    for (int p = 0; p < PAIRS; p++) total = total + $signed(psum[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else if (adv) begin
      out_valid <= vb;
      if (vb) out_product <= total;
    end
  end

  // R6: a refused product is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  // R7: a taken product with nothing behind it is not presented again
  a_r7_single_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !vb) |=> !out_valid);

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csd_mult_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PROD_W = DATA_W + FRAC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic              in_neg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_product
);

  logic                         adv;
  logic                         va, nega, vb;
  logic signed [PROD_W-1:0]     xa, x3a, x5a;
  logic [SEL_W-1:0]             sela;
  logic [PAIRS-1:0][PROD_W-1:0] psum;

  // The whole pipeline moves together unless a held product is refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  csd_base_stage #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_base (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(in_valid), .in_sample(in_sample), .in_sel(in_sel), .in_neg(in_neg),
    .va(va), .xa(xa), .x3a(x3a), .x5a(x5a), .sela(sela), .nega(nega)
  );

  csd_pair_stage #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .va(va), .xa(xa), .x3a(x3a), .x5a(x5a), .sela(sela), .nega(nega),
    .vb(vb), .psum(psum)
  );

  csd_final_stage #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_final (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .vb(vb), .psum(psum), .out_ready(out_ready),
    .out_valid(out_valid), .out_product(out_product)
  );

endmodule

// File: tb/tb_csd_const_mult.sv
`timescale 1ns/1ps
module tb_csd_const_mult;

  localparam int DW = 8;
  localparam int PW = DW + 12;
  localparam int N_ITEMS = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_sample = '0;
  logic [2:0]    in_sel = '0;
  logic          in_neg = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_product;

  int total = 0;
  int bad = 0;
  longint exp_q[$];
  string  tag_q[$];

  always #2 clk = ~clk;

  csd_const_mult #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_sel(in_sel), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_product(out_product)
  );

  function automatic longint kval(input int s);
    case (s)
      1: return 2008;
      2: return 1892;
      3: return 1702;
      4: return 1448;
      5: return 1137;
      6: return 783;
      7: return 399;
      default: return 0;
    endcase
  endfunction

  function automatic longint prod_s();
    return longint'($signed(out_product));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int x, input int s, input bit n);
    in_valid  = 1'b1;
    in_sample = DW'(x);
    in_sel    = 3'(s);
    in_neg    = n;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    longint a_exp, b_exp, c_exp;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R2: constants track the ideal cosines
    for (int s = 1; s <= 7; s++) begin
      real ideal, d;
      ideal = $cos(s * 3.14159265358979 / 16.0) / 2.0 * 4096.0;
      d = real'(kval(s)) - ideal;
      check(d < 1.0 && d > -1.0, $sformatf("R2 sel%0d", s), kval(s), longint'(ideal));
    end

    // R5: latency with an empty pipeline
    out_ready = 1'b1;
    @(negedge clk);
    drive(100, 3, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5 edge1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 edge2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5 edge3 valid", out_valid, 1);
    check(prod_s() == 170200, "R5 value", prod_s(), 170200);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", out_valid, 0);

    // R6: stall with three products in flight
    out_ready = 1'b0;
    a_exp = -128 * 2008;
    b_exp = -(127 * 2008);
    c_exp = -1 * 1137;
    drive(-128, 1, 1'b0);
    @(negedge clk);
    drive(127, 1, 1'b1);
    @(negedge clk);
    drive(-1, 5, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(out_valid == 1'b1, "R6 held valid", out_valid, 1);
      check(prod_s() == a_exp, "R6 held value", prod_s(), a_exp);
      check(in_ready == 1'b0, "R7 ready low in stall", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check(prod_s() == a_exp, "R9 first out", prod_s(), a_exp);
    @(negedge clk);
    check(out_valid && prod_s() == b_exp, "R3 second out", prod_s(), b_exp);
    @(negedge clk);
    check(out_valid && prod_s() == c_exp, "R7 third out", prod_s(), c_exp);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no duplicate", out_valid, 0);

    // Full sweep: every sample, select and sign, random gaps and back-pressure
    begin
      int idx = 0;
      logic [15:0] lfsr = 16'hACE1;
      bit prev_stall = 1'b0;
      bit pending = 1'b0;
      logic [PW-1:0] prev_prod = '0;
      while (idx < N_ITEMS || exp_q.size() > 0) begin
        @(negedge clk);
        if (prev_stall)
          check(out_valid && out_product == prev_prod, "R6 sweep hold",
                prod_s(), longint'($signed(prev_prod)));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = lfsr[0] | lfsr[3];
        if (idx < N_ITEMS) begin
          int sx;
          sx = (idx >> 4) - 128;
          drive(sx, (idx >> 1) & 7, idx[0]);
          in_valid = pending | lfsr[5] | lfsr[7] | lfsr[9];
        end else begin
          in_valid = 1'b0;
        end
        #1;
        check(in_ready == (!out_valid || out_ready), "R7 ready rule", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected output", prod_s(), 0);
          end else begin
            longint e;
            string  t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(prod_s() == e, t, prod_s(), e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_prod  = out_product;
        pending    = in_valid && !in_ready;
        if (in_valid && in_ready) begin
          int sx, s;
          bit n;
          sx = (idx >> 4) - 128;
          s  = (idx >> 1) & 7;
          n  = idx[0];
          exp_q.push_back(n ? -(longint'(sx) * kval(s)) : longint'(sx) * kval(s));
          if (s == 0)                    tag_q.push_back("R4 zero select");
          else if (sx == -128 || sx == 127) tag_q.push_back("R9 full scale");
          else if (n)                    tag_q.push_back("R3 negated");
          else                           tag_q.push_back("R1 product");
          idx++;
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule